// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-mapped management master for Clause 22 PHY access. Software builds a complete 32-bit management frame in one word and writes it to the frame register. The controller then drives a preamble of all ones on the serial data line, followed by the 32 frame bits. MDIO changes on the falling edge of MDC, and the PHY samples it on the rising edge. For a read, the controller releases the data line for the turnaround and data fields. It shifts the 16 bits returned by the PHY into the low half of the same frame register. At the end of every frame a sticky completion flag is set, and software clears it by writing a one.

MDC is derived from the system clock through a 6-bit divider S. S is held at bits 6:1 of the speed register, and each MDC half period lasts S system clocks. To keep MDC at or below 2.5 MHz, software chooses S as the system clock divided by 5 MHz, rounded up and capped at 63. A frame starts only under three conditions: management mode is enabled, S is not zero, and no frame is in flight. Any other frame write is dropped.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After synchronous reset, the frame, speed, event and control registers all read 0, MDC is low and the MDIO output enable is low.
- R2: Each transaction drives 32 MDC cycles of MDIO high, then the 32 frame-register bits MSB first (bit 31 first). MDIO changes only on falling MDC edges, so the value is stable at each rising edge.
- R3: The MDC period is 2*S system clocks. S is bits 6:1 of the speed register (address 1). Bit 0 and bits 31:7 of a speed write are ignored, and the register reads back as S<<1.
- R4: While S is 0, MDC stays low and a frame-register write starts no transaction.
- R5: A frame whose bits 29:28 equal 10 is a read. The output enable is low for the last 18 MDC cycles (frame bits 17:0). MDIO input is sampled on rising MDC edges of the last 16 cycles, MSB first. On completion, frame register bits 15:0 hold those 16 bits and bits 31:16 are unchanged.
- R6: For any other opcode, the output enable stays high for all 64 MDC cycles of the transaction, and the frame register reads back unchanged afterwards.
- R7: Event register (address 2) bit 0 is set when a transaction completes. It stays set until a write to address 2 with bit 0 equal to 1, and a write with bit 0 equal to 0 leaves it set.
- R8: Control register (address 3) bit 0 is the management enable. A frame write (address 0) while it is 0 leaves the frame register unchanged and starts nothing.
- R9: A frame write while a transaction is busy is ignored. The running frame continues, and the frame register keeps the first word.
- R10: Event register bit 1 reads 1 from the cycle after a frame is accepted until the transaction completes, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 frame, 1 speed, 2 event, 3 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench drives random read and write frames with random PHY addresses, register addresses, payloads and returned data. Each frame runs at a random divider value, and the speed word carries random bits outside 6:1. A behavioural PHY records every rising-edge MDIO bit and output-enable level, and checks them against a preamble-plus-frame model, so wrong bit order is separated from wrong release timing. Directed cases then cover a write while busy, a write with management disabled, a zero divider, and a write of zero to the event register. These show the difference between dropped commands and corrupted state.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_SPEED = 2'd1,
    SEL_EVENT = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  localparam logic [1:0] OPC_READ = 2'b10;

  function automatic logic frame_is_read(input logic [31:0] w);
    return w[29:28] == OPC_READ;
  endfunction

  function automatic logic [5:0] speed_field(input logic [31:0] w);
    return w[6:1];
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit      = run && (div != '0) && (cnt == div - DIV_W'(1));
  assign rise_stb = hit && !mdc;
  assign fall_stb = hit && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run || div == '0) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               rise_stb,
  input  logic               fall_stb,
  input  logic               mdio_i,
  output logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done_pulse,
  output logic               is_read
);
  localparam int TOTAL      = PRE_LEN + FRAME_W;
  localparam int CNT_W      = $clog2(TOTAL);
  localparam int REL_IDX    = TOTAL - 18;
  localparam int DATA_IDX   = TOTAL - 16;

  logic [CNT_W-1:0] bitcnt;
  logic [CNT_W-1:0] nxt;

  function automatic logic bit_at(input logic [FRAME_W-1:0] f, input int idx);
    if (idx < PRE_LEN) return 1'b1;
    return f[FRAME_W-1-(idx-PRE_LEN)];
  endfunction

  function automatic logic released(input logic rd, input int idx);
    return rd && idx >= REL_IDX;
  endfunction

  assign is_read    = frame_is_read(32'(frame));
  assign nxt        = bitcnt + CNT_W'(1);
  assign done_pulse = busy && fall_stb && (int'(bitcnt) == TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame   <= '0;
      busy    <= 1'b0;
      bitcnt  <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (start) begin
      frame   <= load_word;
      busy    <= 1'b1;
      bitcnt  <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_stb && is_read && int'(bitcnt) >= DATA_IDX)
        frame[15:0] <= {frame[14:0], mdio_i};
      if (done_pulse) begin
        busy    <= 1'b0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end else if (fall_stb) begin
        bitcnt  <= nxt;
        mdio_o  <= bit_at(frame, int'(nxt));
        mdio_oe <= !released(is_read, int'(nxt));
      end
    end
  end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_W = 32;

  logic [DIV_W-1:0]   spd_div;
  logic               mgmt_en;
  logic               evt;
  logic               busy;
  logic               rise_stb;
  logic               fall_stb;
  logic               done_pulse;
  logic               is_read;
  logic               start;
  logic               clr_evt;
  logic [FRAME_W-1:0] frame_q;
  logic [15:0]        frame_hi;

  assign start    = bus_wr && bus_addr == SEL_FRAME && mgmt_en && spd_div != '0 && !busy;
  assign clr_evt  = bus_wr && bus_addr == SEL_EVENT && bus_wdata[0];
  assign frame_hi = frame_q[31:16];

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div(spd_div),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W)) u_eng (
    .clk(clk), .rst(rst), .start(start), .load_word(bus_wdata),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .frame(frame_q), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done_pulse(done_pulse), .is_read(is_read)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spd_div <= '0;
      mgmt_en <= 1'b0;
      evt     <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == SEL_SPEED) spd_div <= DIV_W'(speed_field(bus_wdata));
      if (bus_wr && bus_addr == SEL_CTRL)  mgmt_en <= bus_wdata[0];
      if (done_pulse)   evt <= 1'b1;
      else if (clr_evt) evt <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel_e'(bus_addr))
      SEL_FRAME: bus_rdata = frame_q;
      SEL_SPEED: bus_rdata = 32'(spd_div) << 1;
      SEL_EVENT: bus_rdata = {30'd0, busy, evt};
      default:   bus_rdata = {31'd0, mgmt_en};
    endcase
  end
endmodule

// File: rtl/mdio_frame_chk.sv
module mdio_frame_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        is_read,
  input logic        done_pulse,
  input logic        evt,
  input logic        clr_evt,
  input logic [15:0] frame_hi
);
  // R4
  mdc_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdc);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdio_oe);
  // R6
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst) (busy && !is_read) |-> mdio_oe);
  // R7
  evt_set_chk: assert property (@(posedge clk) disable iff (rst) done_pulse |=> evt);
  // R7
  evt_hold_chk: assert property (@(posedge clk) disable iff (rst) (evt && !clr_evt) |=> evt);
  // R9
  hdr_stable_chk: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(frame_hi));
endmodule

bind mdio_frame_ctrl mdio_frame_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mdc(mdc), .mdio_oe(mdio_oe),
  .is_read(is_read), .done_pulse(done_pulse), .evt(evt),
  .clr_evt(clr_evt), .frame_hi(frame_hi)
);

// File: tb/mdio_frame_ctrl_bench.sv
module mdio_frame_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          cyc = 0;
  int          rise_idx = 0;
  int          fall_idx = 0;
  int          last_rise = 0;
  int          exp_per = 0;
  int          per_bad = 0;
  logic [63:0] rec_o, rec_oe;
  logic [15:0] phy_val = 16'h0;

  mdio_frame_ctrl u_mdio_frame_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    if (rise_idx < 64) begin
      rec_o[rise_idx]  = mdio_o;
      rec_oe[rise_idx] = mdio_oe;
    end
    if (rise_idx > 0 && (cyc - last_rise) != exp_per) per_bad = per_bad + 1;
    last_rise = cyc;
    rise_idx  = rise_idx + 1;
  end

  always @(negedge mdc) begin
    fall_idx = fall_idx + 1;
    if (fall_idx >= 48 && fall_idx < 64) mdio_i = phy_val[15-(fall_idx-48)];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic exp_bit(input logic [31:0] w, input int i);
    return (i < 32) ? 1'b1 : w[31-(i-32)];
  endfunction

  function automatic logic exp_oe(input logic [31:0] w, input int i);
    return !(w[29:28] == 2'b10 && i >= 46);
  endfunction

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int k = 0; k < 20000; k++) begin
      rd(2'd2, v);
      if (!v[1]) begin ok = 1; break; end
    end
  endtask

  task automatic run_txn(input logic [31:0] word, input int s, input logic [15:0] pv, input bit inject);
    logic [31:0] v, expw;
    bit ok;
    int bad_o, bad_oe;
    bit rdop;
    rdop = (word[29:28] == 2'b10);
    wr(2'd1, {$urandom, 1'b0} & 32'hFFFF_FF81 | (32'(s) << 1) | 32'($urandom & 1));
    rise_idx = 0; fall_idx = 0; per_bad = 0; exp_per = 2 * s; phy_val = pv; mdio_i = 1'b1;
    wr(2'd0, word);
    rd(2'd2, v);
    // R10: busy bit set while a frame is in flight
    chk(v[1] == 1'b1, "R10 busy set", v, 32'h2);
    if (inject) begin
      wr(2'd0, ~word);
      // R9: frame register keeps first word
      rd(2'd0, v);
      chk(v == word, "R9 busy write dropped", v, word);
    end
    wait_idle(ok);
    chk(ok, "R10 busy clears", 32'(ok), 32'd1);
    bad_o = 0; bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      if (exp_oe(word, i) && rec_o[i] !== exp_bit(word, i)) bad_o++;
      if (rec_oe[i] !== exp_oe(word, i)) bad_oe++;
    end
    // R2: preamble and MSB-first frame bits
    chk(rise_idx == 64 && bad_o == 0, "R2 serial bits", 32'(bad_o), 32'd0);
    chk(bad_oe == 0, rdop ? "R5 oe release" : "R6 oe held", 32'(bad_oe), 32'd0);
    // R3: MDC period 2*S
    chk(per_bad == 0, "R3 mdc period", 32'(per_bad), 32'(exp_per));
    rd(2'd1, v);
    chk(v == 32'(s) << 1, "R3 speed readback", v, 32'(s) << 1);
    expw = rdop ? {word[31:16], pv} : word;
    rd(2'd0, v);
    chk(v == expw, rdop ? "R5 read data" : "R6 frame unchanged", v, expw);
    rd(2'd2, v);
    chk(v[0] == 1'b1, "R7 event set", v, 32'h1);
    wr(2'd2, 32'h0);
    rd(2'd2, v);
    chk(v[0] == 1'b1, "R7 zero write keeps event", v, 32'h1);
    wr(2'd2, 32'h1);
    rd(2'd2, v);
    chk(v == 32'h0, "R7 event cleared", v, 32'h0);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w;
    int s;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 32'h0, "R1 reg reset", v, 32'h0);
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {30'd0, mdc, mdio_oe}, 32'h0);

    // R8: disabled management drops a command
    wr(2'd1, 32'h0000_0004);
    wr(2'd0, 32'h6082_0000);
    repeat (10) @(negedge clk);
    rd(2'd0, v);
    chk(v == 32'h0, "R8 frame unchanged", v, 32'h0);
    rd(2'd2, v);
    chk(v == 32'h0 && mdc == 1'b0, "R8 no transaction", v, 32'h0);

    wr(2'd3, 32'h1);
    // R4: zero divider keeps block idle
    wr(2'd1, 32'hFFFF_FF81);
    wr(2'd0, 32'h5012_3456);
    repeat (10) @(negedge clk);
    rd(2'd0, v);
    chk(v == 32'h0 && mdc == 1'b0, "R4 zero divider idle", v, 32'h0);
    rd(2'd2, v);
    chk(v == 32'h0, "R4 no event", v, 32'h0);

    // directed: read and write at divider 1, write while busy
    run_txn(32'h6002_0000 | (32'd3 << 23) | (32'd1 << 18), 1, 16'hA55A, 0);
    run_txn(32'h5002_0000 | (32'd31 << 23) | (32'd31 << 18) | 32'hFFFF, 1, 16'h0, 0);
    run_txn(32'h5002_0000 | (32'd5 << 23) | 32'h1234, 2, 16'h0, 1);

    // random frames
    for (int n = 0; n < 8; n++) begin
      s = 1 + int'($urandom % 4);
      w = (($urandom & 1) ? 32'h6002_0000 : 32'h5002_0000)
          | ((32'($urandom) & 32'h1F) << 23) | ((32'($urandom) & 32'h1F) << 18)
          | (32'($urandom) & 32'hFFFF);
      if (w[29:28] == 2'b10) w[15:0] = 16'h0;
      run_txn(w, s, 16'($urandom), n == 3);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule